// File: doc/BRIEF.md
# Flow-Control Update Packet Scheduler

This block sits on a device's transmit path and decides when the device should tell the host how far it has got through the transmit stream. The transmit packet parser hands it one report for every consumed packet. The report carries the 32-bit sequence word from the front of that packet, already assembled from its big-endian byte order. The scheduler remembers the newest consumed sequence number. When an update is due, it offers that number on an output stream. A packet builder downstream turns it into a status message for the host.

Two triggers can make an update due. The first counts consumed packets. The second counts clock cycles. Each trigger has its own 32-bit control register on a small write port. Bit 31 of the register enables the trigger, and bits 30:0 hold the interval. Writing zero turns the trigger off. Host software usually sets the packet interval to the buffer size divided by the number of updates per buffer and by the frame size (for example a 1 MiB buffer with 8 updates per buffer). It usually sets the cycle interval to the clock rate divided by the wanted update rate (for example 100 per second).

The consumed-packet input never applies back-pressure: cons_ready is always high, and a report is taken in every cycle in which cons_valid is high. The update output follows valid/ready rules. Once upd_valid is high it stays high until a cycle with upd_ready high. If a new update becomes due while one is still waiting, the two merge into one update, and upd_seq moves to the newer value.

Top module: `fc_update_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, upd_valid is 0 and cons_ready is 1.
- R2: Set the packet register (offset 5) to enable bit 31 set with interval N. Then upd_valid rises in the cycle after the N-th consumed packet, and upd_seq equals that packet's sequence word. The count starts again after each update.
- R3: Set the cycle register (offset 4) to enable bit 31 set with interval C, with a packet already consumed. Then an update is raised C cycles after the register write, and again every C cycles after that. It carries the newest consumed sequence number.
- R4: A trigger whose register has bit 31 clear, or whose interval is zero, never raises an update.
- R5: A write is decoded only at offset 4 (cycle interval) and offset 5 (packet interval). Writes to any other offset change nothing.
- R6: No update is raised until at least one packet has been consumed since reset. A cycle trigger that expires before then is dropped.
- R7: When either trigger fires, both the packet count and the cycle count start again from zero.
- R8: A waiting update holds upd_valid high until upd_ready is high. A trigger that fires while an update is waiting does not queue a second update. It replaces upd_seq with the newest sequence number, and exactly one handshake follows.
- R9: cons_ready is high in every cycle after reset.
- R10: Writing a trigger's register restarts that trigger's count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (3) | Register offset in the transmit-control space |
| cfg_wdata | input | 32 | Write data: bit 31 enable, bits 30:0 interval |
| cons_valid | input | 1 | A packet has been consumed |
| cons_ready | output | 1 | Always high; the scheduler never stalls the parser |
| cons_seq | input | SEQ_W (32) | Sequence word of the consumed packet |
| upd_valid | output | 1 | An update is waiting to be sent |
| upd_ready | input | 1 | The packet builder accepts the update |
| upd_seq | output | SEQ_W (32) | Sequence number to report to the host |

## Verification
The bench lets the cycle timer expire before any packet has arrived. A design that skips the first-packet guard would report a sequence number the host never sent. It also lets one trigger fire partway through the other trigger's interval, so a design that clears only the trigger that fired would produce an extra, early update. It holds upd_ready low while updates keep arriving: a design that queues them would make more than one handshake, and a design that keeps the first value would report a stale sequence number. Finally, it writes to other offsets, sets an interval with the enable bit clear, and sets enable with a zero interval. A design with a loose address decode, or one that runs a zero-length interval, would raise updates where none are due.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam int unsigned CFG_W  = 32;
  localparam int unsigned IVAL_W = CFG_W - 1;
  localparam int unsigned NSRC   = 2;
  localparam int unsigned SRC_CYC = 0;
  localparam int unsigned SRC_PKT = 1;

  typedef struct packed {
    logic              en;
    logic [IVAL_W-1:0] ival;
  } fcu_cfg_t;
endpackage

// File: rtl/fcu_cfg_regs.sv
module fcu_cfg_regs
  import fcu_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned CYC_OFS = 4,
  parameter int unsigned PKT_OFS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CFG_W-1:0]     wr_data,
  output fcu_cfg_t [NSRC-1:0]  cfg_q,
  output logic [NSRC-1:0]      cfg_wr
);
  localparam logic [ADDR_W-1:0] OFS_CYC = ADDR_W'(CYC_OFS);
  localparam logic [ADDR_W-1:0] OFS_PKT = ADDR_W'(PKT_OFS);

  for (genvar g = 0; g < NSRC; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_OFS = (g == SRC_CYC) ? OFS_CYC : OFS_PKT;
    assign cfg_wr[g] = wr_en && (wr_addr == MY_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (cfg_wr[g]) begin
        cfg_q[g] <= fcu_cfg_t'(wr_data);
      end
    end
  end
endmodule

// File: rtl/fcu_interval_ctr.sv
module fcu_interval_ctr
  import fcu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  fcu_cfg_t cfg,
  input  logic     clear,
  input  logic     step,
  input  logic     restart,
  output logic     hit
);
  logic [IVAL_W-1:0] cnt;
  logic              active;

  assign active = cfg.en && (cfg.ival != '0);
  assign hit    = active && step && (cnt == (cfg.ival - IVAL_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || restart || !active) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + IVAL_W'(1);
    end
  end
endmodule

// File: rtl/fcu_update_out.sv
module fcu_update_out #(
  parameter int unsigned SEQ_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [SEQ_W-1:0] req_seq,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SEQ_W-1:0] out_seq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_seq   <= '0;
    end else if (req) begin
      out_valid <= 1'b1;
      out_seq   <= req_seq;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fc_update_sched.sv
module fc_update_sched
  import fcu_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SEQ_W   = 32,
  parameter int unsigned CYC_OFS = 4,
  parameter int unsigned PKT_OFS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cons_valid,
  output logic              cons_ready,
  input  logic [SEQ_W-1:0]  cons_seq,
  output logic              upd_valid,
  input  logic              upd_ready,
  output logic [SEQ_W-1:0]  upd_seq
);
  fcu_cfg_t [NSRC-1:0] cfg_q;
  logic [NSRC-1:0]     cfg_wr;
  logic [NSRC-1:0]     src_step;
  logic [NSRC-1:0]     src_hit;
  logic                cons_fire;
  logic                seen_q;
  logic [SEQ_W-1:0]    last_seq_q;
  logic [SEQ_W-1:0]    cur_seq;
  logic                terminal;
  logic                upd_req;

  assign cons_ready = 1'b1;
  assign cons_fire  = cons_valid && cons_ready;

  fcu_cfg_regs #(
    .ADDR_W (ADDR_W),
    .CYC_OFS(CYC_OFS),
    .PKT_OFS(PKT_OFS)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_addr(cfg_addr),
    .wr_data(cfg_wdata),
    .cfg_q  (cfg_q),
    .cfg_wr (cfg_wr)
  );

  assign src_step[SRC_CYC] = 1'b1;
  assign src_step[SRC_PKT] = cons_fire;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    fcu_interval_ctr u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg    (cfg_q[g]),
      .clear  (cfg_wr[g]),
      .step   (src_step[g]),
      .restart(terminal),
      .hit    (src_hit[g])
    );
  end

  assign terminal = |src_hit;
  assign upd_req  = terminal && (seen_q || cons_fire);
  assign cur_seq  = cons_fire ? cons_seq : last_seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      last_seq_q <= '0;
    end else if (cons_fire) begin
      seen_q     <= 1'b1;
      last_seq_q <= cons_seq;
    end
  end

  fcu_update_out #(.SEQ_W(SEQ_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (upd_req),
    .req_seq  (cur_seq),
    .out_valid(upd_valid),
    .out_ready(upd_ready),
    .out_seq  (upd_seq)
  );
endmodule

// File: rtl/fcu_sched_chk.sv
module fcu_sched_chk #(
  parameter int unsigned SEQ_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cons_valid,
  input logic             cons_ready,
  input logic [SEQ_W-1:0] cons_seq,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic [SEQ_W-1:0] upd_seq
);
  logic             seen;
  logic [SEQ_W-1:0] newest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      newest <= '0;
    end else if (cons_valid && cons_ready) begin
      seen   <= 1'b1;
      newest <= cons_seq;
    end
  end

  // R8: a waiting update is not withdrawn
  a_r8_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_ready |=> upd_valid);

  // R8: the update only goes away through a handshake
  a_r8_drop_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_valid) |-> $past(upd_ready));

  // R2: a fresh update carries the newest consumed sequence number
  a_r2_rise_newest: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_valid) |-> upd_seq == newest);

  // R6: nothing is offered before the first consumed packet
  a_r6_quiet_before_first: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !upd_valid);
endmodule

bind fc_update_sched fcu_sched_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cons_valid(cons_valid),
  .cons_ready(cons_ready),
  .cons_seq  (cons_seq),
  .upd_valid (upd_valid),
  .upd_ready (upd_ready),
  .upd_seq   (upd_seq)
);

// File: tb/tb_fc_update_sched.sv
module tb_fc_update_sched;
  localparam int unsigned AW = 3;
  localparam int unsigned SW = 32;
  localparam logic [31:0] EN = 32'h8000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          cons_valid = 1'b0;
  logic          cons_ready;
  logic [SW-1:0] cons_seq = '0;
  logic          upd_valid;
  logic          upd_ready = 1'b1;
  logic [SW-1:0] upd_seq;

  int checks = 0;
  int fails = 0;
  int hs = 0;

  always #4 clk = ~clk;

  fc_update_sched dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cons_valid(cons_valid), .cons_ready(cons_ready),
    .cons_seq(cons_seq), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_seq(upd_seq)
  );

  always @(posedge clk) if (rst_n && upd_valid && upd_ready) hs++;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] s);
    @(negedge clk);
    cfg_we = 1'b0; cons_valid = v; cons_seq = s;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cons_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0; cons_valid = 1'b0; upd_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", upd_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    step(0, 0);
    chk("R1 valid after reset", upd_valid, 0);
    chk("R9 ready after reset", cons_ready, 1);
  endtask

  task automatic t_pkt_trigger();
    do_reset();
    wr(5, EN | 3);
    step(1, 10); chk("R2 no update pkt1", upd_valid, 0);
    step(1, 11); chk("R2 no update pkt2", upd_valid, 0);
    step(1, 12); chk("R2 update pkt3", upd_valid, 1); chk("R2 seq pkt3", upd_seq, 12);
    step(1, 13); chk("R2 drop after accept", upd_valid, 0);
    chk("R9 ready while busy", cons_ready, 1);
    step(1, 14); chk("R2 no update pkt5", upd_valid, 0);
    step(1, 15); chk("R2 update pkt6", upd_valid, 1); chk("R2 seq pkt6", upd_seq, 15);
  endtask

  task automatic t_disabled();
    bit any;
    do_reset();
    wr(5, 32'h0000_0002);
    any = 0;
    for (int i = 0; i < 5; i++) begin step(1, 32'h40 + i); any |= upd_valid; end
    chk("R4 enable clear", any, 0);
    wr(5, EN);
    wr(4, EN);
    any = 0;
    for (int i = 0; i < 5; i++) begin step(1, 32'h50 + i); any |= upd_valid; end
    chk("R4 zero interval", any, 0);
  endtask

  task automatic t_bad_offset();
    bit any;
    do_reset();
    wr(3, EN | 1);
    wr(6, EN | 1);
    wr(0, EN | 1);
    any = 0;
    for (int i = 0; i < 4; i++) begin step(1, 32'h60 + i); any |= upd_valid; end
    for (int i = 0; i < 4; i++) begin step(0, 0); any |= upd_valid; end
    chk("R5 other offsets ignored", any, 0);
  endtask

  task automatic t_cycle();
    do_reset();
    step(1, 32'h203);
    wr(4, EN | 5);
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 4; i++) begin
        step(0, 0); chk("R3 quiet inside interval", upd_valid, 0);
      end
      step(0, 0);
      chk("R3 timer update", upd_valid, 1);
      chk("R3 timer seq", upd_seq, 32'h203);
    end
  endtask

  task automatic t_early();
    bit any;
    bit got;
    do_reset();
    wr(4, EN | 3);
    any = 0;
    for (int i = 0; i < 10; i++) begin step(0, 0); any |= upd_valid; end
    chk("R6 no update before first packet", any, 0);
    step(1, 32'h55);
    got = upd_valid;
    for (int i = 0; i < 3; i++) if (!got) begin step(0, 0); got = upd_valid; end
    chk("R6 update after first packet", got, 1);
    chk("R6 seq after first packet", upd_seq, 32'h55);
  endtask

  task automatic t_shared_restart();
    bit any;
    do_reset();
    wr(5, EN | 3);
    wr(4, EN | 8);
    step(1, 1);
    step(1, 2);
    for (int i = 0; i < 5; i++) begin step(0, 0); chk("R7 quiet before timer", upd_valid, 0); end
    step(0, 0);
    chk("R7 timer update", upd_valid, 1); chk("R7 timer seq", upd_seq, 2);
    step(1, 3); chk("R7 packet count restarted by timer", upd_valid, 0);
    step(1, 4);
    step(1, 5); chk("R7 packet update", upd_valid, 1); chk("R7 packet seq", upd_seq, 5);
    any = 0;
    for (int i = 0; i < 7; i++) begin step(0, 0); any |= upd_valid; end
    chk("R7 timer restarted by packet trigger", any, 0);
    step(0, 0); chk("R7 timer after restart", upd_valid, 1);
  endtask

  task automatic t_merge();
    int hs0;
    do_reset();
    wr(5, EN | 1);
    upd_ready = 1'b0;
    hs0 = hs;
    step(1, 32'hA); chk("R8 first update", upd_valid, 1); chk("R8 first seq", upd_seq, 32'hA);
    step(1, 32'hB); chk("R8 still pending", upd_valid, 1); chk("R8 merged seq", upd_seq, 32'hB);
    step(0, 0); step(0, 0);
    chk("R8 held without ready", upd_valid, 1); chk("R8 held seq", upd_seq, 32'hB);
    upd_ready = 1'b1;
    step(0, 0);
    chk("R8 released", upd_valid, 0);
    chk("R8 single handshake", hs - hs0, 1);
  endtask

  task automatic t_rewrite();
    do_reset();
    wr(5, EN | 3);
    step(1, 7); step(1, 8);
    wr(5, EN | 3);
    step(1, 9); step(1, 32'hA);
    chk("R10 count restarted by write", upd_valid, 0);
    step(1, 32'hB);
    chk("R10 update after rewrite", upd_valid, 1);
    chk("R10 seq after rewrite", upd_seq, 32'hB);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_pkt_trigger();
    t_disabled();
    t_bad_offset();
    t_cycle();
    t_early();
    t_shared_restart();
    t_merge();
    t_rewrite();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule